// File: doc/BRIEF.md
# Synchronous Byte-to-Serial Configuration Loader

This block is the receiving end of a byte-wide configuration port that runs on a clock supplied from outside. Once the init line has been seen to go from low to high, it takes one byte from an 8-bit data bus on a fixed schedule. The schedule never waits on a handshake. The first byte is taken on the second rising edge after init rises. Every later byte is taken eight selected rising edges after the one before. Both chip selects gate the schedule. While the port is not selected, the schedule stands still.

Each captured byte goes out one bit at a time on a serial line for the next device in a daisy chain. The bits leave least significant first, with each bit launched on a falling clock edge. A one-cycle acknowledge pulse follows every capture. The block counts the captured bytes against a programmed total. It raises done once that total has been taken and the last bit has been held on the serial line for a full cycle. An active-low program input clears the block and sends it back to waiting for init to rise.

Top module: `cfg_serial_loader`

## Requirements
- R1: While rst_n is low, and right after it is released, ser_out is 1 and byte_ack and done are 0.
- R2: Call the first rising edge at which init_n is sampled high, after being sampled low at the edge before it, edge 1. If the port is selected, the first byte is captured from din at edge 2.
- R3: After a capture, the next byte is captured at the eighth selected rising edge that follows it. Values on din at any other edge have no effect on ser_out.
- R4: The port is selected when sel_n is 0 and sel is 1. A rising edge without selection captures nothing and does not advance the schedule.
- R5: byte_ack is 1 for exactly one clock cycle, from the rising edge after a capture until the rising edge after that.
- R6: ser_out is 1 when no byte is being sent. A byte captured at rising edge n appears on ser_out least significant bit first. Bit i is driven from the falling edge that follows rising edge n+i, for i from 0 to 7.
- R7: done rises at the ninth rising edge after the TOTAL_BYTES-th capture and then stays high. No further capture or byte_ack occurs while done is high.
- R8: A rising edge with prog_n at 0 clears the byte count, byte_ack and done. A falling edge with prog_n at 0 returns ser_out to 1. After that, no capture occurs until init_n is sampled low and then high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cfg | input | 1 | Externally supplied configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_n | input | 1 | Active-low synchronous clear and restart |
| init_n | input | 1 | Init release; a low-to-high change arms the capture schedule |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| din | input | DATA_W | Parallel configuration byte |
| ser_out | output | 1 | Serial data to the next device, least significant bit first, idle 1 |
| byte_ack | output | 1 | One-cycle acknowledge after each captured byte |
| done | output | 1 | Programmed byte total captured and fully shifted out |

## Verification
Capture of the next byte and the drain of the current byte into the serial line meet in the same rising edge. That is the edge where the shifter is handed a new byte while the previous one's last bit is still on ser_out. The bench provokes this on every back-to-back byte with no pause. It also provokes it after pauses of the chip selects that move the capture edge, including a pause that covers the first capture. It judges the meeting point by checking ser_out after every falling edge against the bit position computed from the capture edge, so that a lost, repeated or shifted bit at the hand-over shows up. In the same way, done must rise exactly when the last byte has drained, not when it is captured.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DONE  = 2'd3
  } ldr_state_e;

endpackage

// File: rtl/cfgl_sched.sv
module cfgl_sched
  import cfgl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TOTAL_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_n,
  input  logic              init_n,
  input  logic              sel_n,
  input  logic              sel,
  input  logic [DATA_W-1:0] din,
  input  logic              shift_busy,
  output logic              cap_pulse,
  output logic [DATA_W-1:0] cap_data,
  output logic              byte_ack,
  output logic              done
);

  localparam int PH_W  = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam int CNT_W = $clog2(TOTAL_BYTES + 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TOTAL_BYTES - 1);

  ldr_state_e        state_q, state_d;
  logic              init_q, init_d;
  logic [PH_W-1:0]   phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cap_q, cap_d;
  logic [DATA_W-1:0] data_q;
  logic              ack_q, ack_d;
  logic              done_q, done_d;
  logic              selected;
  logic              capture;

  assign selected = ~sel_n & sel;
  assign capture  = (state_q == ST_RUN) & selected & (phase_q == '0);

  // next-state logic
  always_comb begin
    state_d = state_q;
    init_d  = init_n;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cap_d   = 1'b0;
    ack_d   = cap_q;
    done_d  = done_q;
    if (!prog_n) begin
      state_d = ST_WAIT;
      phase_d = '0;
      cnt_d   = '0;
      ack_d   = 1'b0;
      done_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (init_n && !init_q) begin
            state_d = ST_RUN;
            phase_d = '0;
          end
        end
        ST_RUN: begin
          if (selected) begin
            if (phase_q == '0) begin
              cap_d   = 1'b1;
              cnt_d   = cnt_q + CNT_W'(1);
              phase_d = PH_LAST;
              if (cnt_q == LAST_CNT) state_d = ST_FLUSH;
            end else begin
              phase_d = phase_q - PH_W'(1);
            end
          end
        end
        ST_FLUSH: begin
          if (!cap_q && !shift_busy) begin
            state_d = ST_DONE;
            done_d  = 1'b1;
          end
        end
        ST_DONE: begin
          done_d = 1'b1;
        end
        default: state_d = ST_WAIT;
      endcase
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      init_q  <= 1'b1;
      phase_q <= '0;
      cnt_q   <= '0;
      cap_q   <= 1'b0;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      init_q  <= init_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      cap_q   <= cap_d;
      ack_q   <= ack_d;
      done_q  <= done_d;
    end
  end

  // data register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cap_d) begin
      data_q <= din;
    end
  end

  assign cap_pulse = cap_q;
  assign cap_data  = data_q;
  assign byte_ack  = ack_q;
  assign done      = done_q;

  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

  // R3
  cap_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |=> !cap_q);

  // R4
  desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!selected && prog_n) |=> $stable(cnt_q));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && prog_n) |=> done_q);

  // R7
  no_cap_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !capture);

  // R8
  prog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |=> (!done_q && !ack_q && cnt_q == '0));

endmodule

// File: rtl/cfgl_shifter.sv
module cfgl_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              ser_out,
  output logic              busy
);

  localparam int LEFT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [LEFT_W-1:0] LEFT_INIT = LEFT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              busy_q, busy_d;

  // next-state logic for the falling-edge shifter
  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    busy_d = busy_q;
    if (!prog_n) begin
      sh_d   = '1;
      left_d = '0;
      busy_d = 1'b0;
    end else if (load) begin
      sh_d   = load_data;
      left_d = LEFT_INIT;
      busy_d = 1'b1;
    end else if (left_q != '0) begin
      sh_d   = {1'b1, sh_q[DATA_W-1:1]};
      left_d = left_q - LEFT_W'(1);
    end else if (busy_q) begin
      sh_d   = {1'b1, sh_q[DATA_W-1:1]};
      busy_d = 1'b0;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      busy_q <= busy_d;
    end
  end

  assign ser_out = sh_q[0];
  assign busy    = busy_q;

  // R6
  idle_high_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !busy_q |-> sh_q[0]);

  // R6
  load_first_bit_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (load && prog_n) |=> (sh_q[0] == $past(load_data[0])));

  // R8
  shift_clear_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !prog_n |=> (!busy_q && sh_q[0]));

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int DATA_W      = 8,
  parameter int TOTAL_BYTES = 4
) (
  input  logic              clk_cfg,
  input  logic              rst_n,
  input  logic              prog_n,
  input  logic              init_n,
  input  logic              sel_n,
  input  logic              sel,
  input  logic [DATA_W-1:0] din,
  output logic              ser_out,
  output logic              byte_ack,
  output logic              done
);

  logic              cap_pulse;
  logic [DATA_W-1:0] cap_data;
  logic              shift_busy;

  cfgl_sched #(
    .DATA_W      (DATA_W),
    .TOTAL_BYTES (TOTAL_BYTES)
  ) u_sched (
    .clk        (clk_cfg),
    .rst_n      (rst_n),
    .prog_n     (prog_n),
    .init_n     (init_n),
    .sel_n      (sel_n),
    .sel        (sel),
    .din        (din),
    .shift_busy (shift_busy),
    .cap_pulse  (cap_pulse),
    .cap_data   (cap_data),
    .byte_ack   (byte_ack),
    .done       (done)
  );

  cfgl_shifter #(
    .DATA_W (DATA_W)
  ) u_shifter (
    .clk       (clk_cfg),
    .rst_n     (rst_n),
    .prog_n    (prog_n),
    .load      (cap_pulse),
    .load_data (cap_data),
    .ser_out   (ser_out),
    .busy      (shift_busy)
  );

endmodule

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TOT        = 4;

  logic       clk_cfg = 1'b0;
  logic       rst_n;
  logic       prog_n;
  logic       init_n;
  logic       sel_n;
  logic       sel;
  logic [7:0] din;
  logic       ser_out;
  logic       byte_ack;
  logic       done;

  int checks = 0;
  int errors = 0;

  cfg_serial_loader #(
    .DATA_W      (8),
    .TOTAL_BYTES (TOT)
  ) u_dut (
    .clk_cfg  (clk_cfg),
    .rst_n    (rst_n),
    .prog_n   (prog_n),
    .init_n   (init_n),
    .sel_n    (sel_n),
    .sel      (sel),
    .din      (din),
    .ser_out  (ser_out),
    .byte_ack (byte_ack),
    .done     (done)
  );

  always #(CLK_PERIOD / 2) clk_cfg = ~clk_cfg;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // selection pattern per scenario: bit1 = sel_n, bit0 = sel
  function automatic logic [1:0] sel_pat(input int p, input int n);
    logic [1:0] r;
    r = 2'b01;
    case (p)
      1: if (n >= 5 && n <= 9) r = 2'b11;
      2: if (n >= 9 && n <= 13) r = 2'b00;
      3: if (n >= 12 && n <= 30 && (n % 2) == 1) r = 2'b11;
      4: if (n >= 2 && n <= 3) r = 2'b10;
      default: r = 2'b01;
    endcase
    return r;
  endfunction

  // prepare: clear with prog_n, hold init low for one edge; ends at negedge+2
  task automatic restart();
    prog_n = 1'b0;
    init_n = 1'b0;
    sel_n  = 1'b0;
    sel    = 1'b1;
    din    = 8'h00;
    @(posedge clk_cfg);
    @(negedge clk_cfg); #2;
    prog_n = 1'b1;
    @(posedge clk_cfg);
    @(negedge clk_cfg); #2;
  endtask

  task automatic run_stream(input int p);
    logic [7:0] bytes [TOT];
    int caps = 0;
    int selcnt = 0;
    int last = -100;
    int acks = 0;
    int n = 0;
    bit will_cap;
    bit s;
    logic [1:0] sp;
    logic exp_ser;
    int d;
    for (int k = 0; k < TOT; k++) bytes[k] = 8'((p * 67 + k * 29 + 5 + (k == 1 ? 8'hF0 : 0)) & 8'hFF);
    restart();
    init_n = 1'b1;
    while (n < 200 && !(caps == TOT && n >= last + 14)) begin
      n++;
      sp = sel_pat(p, n);
      sel_n = sp[1];
      sel   = sp[0];
      s = (sp == 2'b01);
      will_cap = (n >= 2) && s && (caps < TOT) && (selcnt + 1 == 1 + 8 * caps);
      din = will_cap ? bytes[caps] : 8'(8'h3C ^ n);
      @(posedge clk_cfg);
      if (n >= 2 && s) selcnt++;
      if (will_cap) begin
        last = n;
        caps++;
      end
      #2;
      if (byte_ack) acks++;
      // R5 acknowledge one cycle after capture; R4 none on paused edges; R7 none after done
      chk($sformatf("R5 R4 ack p%0d n%0d", p, n), 32'(byte_ack), 32'(n == last + 1));
      // R7 done after last byte drained
      chk($sformatf("R7 done p%0d n%0d", p, n), 32'(done), 32'(caps == TOT && n >= last + 9));
      @(negedge clk_cfg); #2;
      d = n - last;
      exp_ser = 1'b1;
      if (d >= 0 && d < 8) exp_ser = bytes[caps-1][d];
      // R6 bit order and idle level; R3 data from scheduled edge; R2 first byte
      chk($sformatf("R6 R3 R2 ser p%0d n%0d", p, n), 32'(ser_out), 32'(exp_ser));
    end
    // R4 R3 one acknowledge per byte despite pauses
    chk($sformatf("R4 R3 ack count p%0d", p), 32'(acks), 32'(TOT));
  endtask

  task automatic prog_test();
    restart();
    init_n = 1'b1;
    din    = 8'h00;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk_cfg);
      @(negedge clk_cfg); #2;
    end
    // byte of zeros is mid-shift here: ser_out is 0 before the clear
    chk("R6 mid-shift zero before clear", 32'(ser_out), 32'(0));
    prog_n = 1'b0;
    @(posedge clk_cfg); #2;
    chk("R8 ack cleared", 32'(byte_ack), 32'(0));
    chk("R8 done cleared", 32'(done), 32'(0));
    @(negedge clk_cfg); #2;
    chk("R8 serial cleared", 32'(ser_out), 32'(1));
    prog_n = 1'b1;
    // init held high: no re-arm, no capture
    for (int i = 0; i < 20; i++) begin
      @(posedge clk_cfg); #2;
      chk("R8 no capture without init rise ack", 32'(byte_ack), 32'(0));
      @(negedge clk_cfg); #2;
      chk("R8 no capture without init rise ser", 32'(ser_out), 32'(1));
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    prog_n = 1'b1;
    init_n = 1'b0;
    sel_n  = 1'b1;
    sel    = 1'b0;
    din    = 8'h00;
    repeat (3) @(posedge clk_cfg);
    #2;
    chk("R1 reset ser_out", 32'(ser_out), 32'(1));
    chk("R1 reset byte_ack", 32'(byte_ack), 32'(0));
    chk("R1 reset done", 32'(done), 32'(0));
    @(negedge clk_cfg); #2;
    rst_n = 1'b1;
    @(posedge clk_cfg); #2;
    chk("R1 after release ack", 32'(byte_ack), 32'(0));
    chk("R1 after release done", 32'(done), 32'(0));
    @(negedge clk_cfg); #2;
    chk("R1 after release ser", 32'(ser_out), 32'(1));
    for (int p = 0; p < 5; p++) run_stream(p);
    prog_test();
    run_stream(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_cfg);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule